// File: doc/BRIEF.md
# Accumulator Processor Core

A 16-bit single-accumulator processor that runs programs out of one shared memory port. Instructions and data travel over the same request strobe, read/write select, 12-bit address bus and pair of 16-bit data buses. Memory is expected to return read data in the same cycle as the request, so every memory access takes exactly one clock.

The core keeps a program counter, an accumulator and an instruction register. A one-bit phase flag chooses between execute and fetch. A memory-referencing instruction uses one execute cycle to touch its operand and one fetch cycle to bring in the next word. A jump does its fetch inside its own execute cycle: the address it issues comes either from the PC or from the operand field. That address passes through the ALU's increment function, and the result goes back into the PC. A stop opcode parks the core until the next reset.

An instruction word carries the opcode in bits 15:12 and the operand address S in bits 11:0. The opcodes are: load 0, store 1, add 2, subtract 3, jump 4, jump-if-non-negative 5, jump-if-non-zero 6, stop 7. Opcodes 8 to 15 also stop.

Top module: `accu_core`

## Requirements
- R1: While `rst_n` is low, `mem_req` is low. The first cycle after release shows `pc_q` = 0, `acc_q` = 0 and `fetch_phase` = 1, and that cycle reads address 0.
- R2: A fetch cycle (`fetch_phase` = 1) reads address `pc_q` and loads the word into the instruction register. The PC becomes `pc_q`+1 and the next cycle is an execute cycle.
- R3: Load, add and subtract (opcodes 0, 2, 3, with the operand in bits 11:0) read address S in one execute cycle. The accumulator becomes Mem[S], ACC+Mem[S] or ACC−Mem[S] (modulo 2^16), and the next cycle is a fetch.
- R4: Store (opcode 1) drives `mem_rnw` low and `mem_wdata` = ACC at address S in its single execute cycle, then goes to fetch. In every other cycle `mem_rnw` is high and `mem_wdata` is 0.
- R5: Jump (opcode 4) reads the word at S as the next instruction in its one execute cycle. The PC becomes S+1 and the phase stays at execute.
- R6: Jump-if-non-negative (opcode 5) behaves as a jump when ACC bit 15 is 0. Otherwise it reads the next instruction at `pc_q` and the PC becomes `pc_q`+1. Either way it takes one cycle.
- R7: Jump-if-non-zero (opcode 6) behaves as a jump when ACC is not zero. Otherwise it falls through as in R6.
- R8: Opcode 7 and opcodes 8 to 15 stop the core. `mem_req` stays low, and `pc_q` and `acc_q` hold until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_req | output | 1 | Memory access request for this cycle |
| mem_rnw | output | 1 | 1 = read, 0 = write |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 16 | Write data; ACC during a store, else 0 |
| mem_rdata | input | 16 | Read data, valid in the same cycle |
| acc_q | output | 16 | Accumulator |
| pc_q | output | 12 | Program counter |
| fetch_phase | output | 1 | Phase flag: 1 = fetch, 0 = execute |

## Verification
One fixed program uses every opcode and is run once for each pair of operands taken from a grid of 0, 1, 5, 0x7FFF, 0x8000 and 0xFFFF. The sums cross the sign boundary both ways and wrap past 2^16. Some pairs make the non-negative jump taken and others not. A zero first operand separates the taken and fall-through cases of the non-zero jump. Every cycle, an instruction-level model in the bench predicts the bus, the PC, the ACC and the phase. The stored words are then checked against sums computed directly from the operands. Runs alternate the stop opcode between 7 and 15, which tells apart a stop that is decoded exactly from one that covers the whole undefined range.

// File: rtl/accu_pkg.sv
// Package: shared widths, opcode values, ALU function codes and the control
// word handed from the decoder to the datapath.
package accu_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 12;
    localparam int OP_W   = DATA_W - ADDR_W;

    localparam logic [OP_W-1:0] OP_LOAD  = 4'd0;
    localparam logic [OP_W-1:0] OP_STORE = 4'd1;
    localparam logic [OP_W-1:0] OP_ADD   = 4'd2;
    localparam logic [OP_W-1:0] OP_SUB   = 4'd3;
    localparam logic [OP_W-1:0] OP_JUMP  = 4'd4;
    localparam logic [OP_W-1:0] OP_JNNEG = 4'd5;
    localparam logic [OP_W-1:0] OP_JNZ   = 4'd6;

    typedef enum logic [2:0] {
        FN_ZERO  = 3'd0,
        FN_PASSB = 3'd1,
        FN_INCB  = 3'd2,
        FN_ADD   = 3'd3,
        FN_SUB   = 3'd4
    } alu_fn_e;

    typedef struct packed {
        logic    addr_from_ir;  // address mux: operand field instead of PC
        logic    b_from_mem;    // ALU B mux: read data instead of address
        logic    acc_en;
        logic    pc_en;
        logic    ir_en;
        logic    acc_drive;     // accumulator onto write data bus
        alu_fn_e alu_fn;
        logic    req;
        logic    rnw;
        logic    next_fetch;    // phase flag for the following cycle
    } ctrl_t;
endpackage

// File: rtl/accu_alu.sv
// Module: combinational ALU. A is the accumulator, B the selected memory
// data or zero-extended address. Assumes the caller picks the function code.
module accu_alu
    import accu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_fn_e      fn,
    output logic [W-1:0] y
);
    // Select the result for the requested function.
    always_comb begin
        unique case (fn)
            FN_PASSB: y = b;
            FN_INCB:  y = b + 1'b1;
            FN_ADD:   y = a + b;
            FN_SUB:   y = a - b;
            default:  y = '0;
        endcase
    end
endmodule

// File: rtl/accu_ctrl.sv
// Module: decode and control. Turns the phase flag, the opcode and the
// accumulator flags into one control word. Assumes a same-cycle memory read.
// During reset the ALU is forced to zero and loaded into PC and ACC.
module accu_ctrl
    import accu_pkg::*;
(
    input  logic            rst_n,
    input  logic            fetch_ph,
    input  logic [OP_W-1:0] opcode,
    input  logic            acc_neg,
    input  logic            acc_zero,
    output ctrl_t           ctl
);
    logic take;

    // Decide whether a jump in the instruction register is taken.
    always_comb begin
        unique case (opcode)
            OP_JUMP:  take = 1'b1;
            OP_JNNEG: take = !acc_neg;
            OP_JNZ:   take = !acc_zero;
            default:  take = 1'b0;
        endcase
    end

    // Build the control word for this cycle.
    always_comb begin
        ctl            = '0;
        ctl.rnw        = 1'b1;
        ctl.alu_fn     = FN_ZERO;
        ctl.next_fetch = fetch_ph;
        if (!rst_n) begin
            ctl.pc_en      = 1'b1;
            ctl.acc_en     = 1'b1;
            ctl.next_fetch = 1'b1;
        end else if (fetch_ph) begin
            ctl.req        = 1'b1;
            ctl.alu_fn     = FN_INCB;
            ctl.pc_en      = 1'b1;
            ctl.ir_en      = 1'b1;
            ctl.next_fetch = 1'b0;
        end else begin
            unique case (opcode)
                OP_LOAD, OP_ADD, OP_SUB: begin
                    ctl.req          = 1'b1;
                    ctl.addr_from_ir = 1'b1;
                    ctl.b_from_mem   = 1'b1;
                    ctl.acc_en       = 1'b1;
                    ctl.next_fetch   = 1'b1;
                    ctl.alu_fn       = (opcode == OP_LOAD) ? FN_PASSB :
                                       (opcode == OP_ADD)  ? FN_ADD : FN_SUB;
                end
                OP_STORE: begin
                    ctl.req          = 1'b1;
                    ctl.rnw          = 1'b0;
                    ctl.addr_from_ir = 1'b1;
                    ctl.acc_drive    = 1'b1;
                    ctl.next_fetch   = 1'b1;
                end
                OP_JUMP, OP_JNNEG, OP_JNZ: begin
                    ctl.req          = 1'b1;
                    ctl.addr_from_ir = take;
                    ctl.alu_fn       = FN_INCB;
                    ctl.pc_en        = 1'b1;
                    ctl.ir_en        = 1'b1;
                    ctl.next_fetch   = 1'b0;
                end
                default: ctl.next_fetch = 1'b0;  // stop: stay parked
            endcase
        end
    end
endmodule

// File: rtl/accu_core.sv
// Module: top of the accumulator core. Holds PC, ACC, IR and the phase flag,
// and routes the address and ALU operand multiplexers. Assumes memory read
// data is valid in the same cycle as mem_req. Reset is synchronous, active low.
module accu_core
    import accu_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          mem_req,
    output logic          mem_rnw,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] acc_q,
    output logic [AW-1:0] pc_q,
    output logic          fetch_phase
);
    localparam int OPW = DW - AW;

    ctrl_t         ctl;
    logic [DW-1:0] ir_q;
    logic [DW-1:0] alu_b;
    logic [DW-1:0] alu_y;

    accu_ctrl u_ctrl (
        .rst_n    (rst_n),
        .fetch_ph (fetch_phase),
        .opcode   (ir_q[DW-1 -: OPW]),
        .acc_neg  (acc_q[DW-1]),
        .acc_zero (acc_q == '0),
        .ctl      (ctl)
    );

    // Address mux and ALU B operand mux.
    always_comb begin
        mem_addr = ctl.addr_from_ir ? ir_q[AW-1:0] : pc_q;
        alu_b    = ctl.b_from_mem ? mem_rdata : {{OPW{1'b0}}, mem_addr};
    end

    accu_alu #(.W(DW)) u_alu (
        .a  (acc_q),
        .b  (alu_b),
        .fn (ctl.alu_fn),
        .y  (alu_y)
    );

    // Memory strobes and write data gating.
    always_comb begin
        mem_req   = ctl.req;
        mem_rnw   = ctl.rnw;
        mem_wdata = ctl.acc_drive ? acc_q : '0;
    end

    // Architectural registers; reset zero arrives through the ALU.
    always_ff @(posedge clk) begin
        if (ctl.pc_en)  pc_q  <= alu_y[AW-1:0];
        if (ctl.acc_en) acc_q <= alu_y;
        fetch_phase <= ctl.next_fetch;
    end

    // Instruction register.
    always_ff @(posedge clk) begin
        if (!rst_n)         ir_q <= '0;
        else if (ctl.ir_en) ir_q <= mem_rdata;
    end
endmodule

// File: rtl/accu_core_chk.sv
// Module: assertion checker for accu_core, bound to every instance.
// Assumes the synchronous active-low reset of the core.
module accu_core_chk
    import accu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_rnw,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [DATA_W-1:0] acc_q,
    input logic [ADDR_W-1:0] pc_q,
    input logic              fetch_phase,
    input logic [DATA_W-1:0] ir_q
);
    logic prev_rst_n;

    // Remember the reset level of the previous cycle.
    always_ff @(posedge clk) prev_rst_n <= rst_n;

    a_r1_idle_in_reset: assert property (@(posedge clk)
        !rst_n |-> !mem_req);

    a_r1_clean_start: assert property (@(posedge clk)
        (rst_n && prev_rst_n === 1'b0) |->
            (pc_q == '0 && acc_q == '0 && fetch_phase && mem_addr == '0));

    a_r2_fetch_step: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_phase |=> (!fetch_phase && pc_q == ADDR_W'($past(pc_q) + 1'b1)));

    a_r2_fetch_bus: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_phase |-> (mem_req && mem_rnw && mem_addr == pc_q));

    a_r3_two_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_phase && ir_q[DATA_W-1 -: 2] == 2'b00) |=> fetch_phase);

    a_r4_write_only_store: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rnw || mem_wdata != '0) |->
            (mem_req && !fetch_phase && ir_q[DATA_W-1 -: OP_W] == OP_STORE));

    a_r5_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_phase && ir_q[DATA_W-1 -: OP_W] == OP_JUMP) |=>
            (!fetch_phase && pc_q == ADDR_W'($past(ir_q[ADDR_W-1:0]) + 1'b1)));

    a_r8_parked: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_req |=> (!mem_req && $stable(pc_q) && $stable(acc_q)));
endmodule

bind accu_core accu_core_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req     (mem_req),
    .mem_rnw     (mem_rnw),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .acc_q       (acc_q),
    .pc_q        (pc_q),
    .fetch_phase (fetch_phase),
    .ir_q        (ir_q)
);

// File: tb/accu_core_test.sv
// Bench: runs one program over a grid of operand pairs, with a lockstep
// instruction-level model and arithmetic checks of the stored results.
module accu_core_test;
    localparam int PERIOD = 10;
    localparam int MW     = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req, mem_rnw, fetch_phase;
    logic [11:0] mem_addr, pc_q;
    logic [15:0] mem_wdata, mem_rdata, acc_q;

    logic [15:0] mem  [0:MW-1];
    logic [15:0] refm [0:MW-1];

    int n_cmp = 0;
    int n_bad = 0;

    always #(PERIOD/2) clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:0]];

    accu_core uut (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_rnw(mem_rnw),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .acc_q(acc_q), .pc_q(pc_q), .fetch_phase(fetch_phase)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string op_tag(input logic fetch, input logic [3:0] op);
        if (fetch) return "R2";
        case (op)
            4'd0, 4'd2, 4'd3: return "R3";
            4'd1:             return "R4";
            4'd4:             return "R5";
            4'd5:             return "R6";
            4'd6:             return "R7";
            default:          return "R8";
        endcase
    endfunction

    task automatic run_prog(input logic [15:0] x, input logic [15:0] y,
                            input logic [15:0] stop_word);
        logic [11:0] rpc;
        logic [15:0] racc, rir;
        logic        rfetch, e_req, e_rnw, take;
        logic [11:0] e_addr, s;
        logic [15:0] e_wdata;
        logic [3:0]  op;
        string       tag;
        int          parked;
        logic [15:0] sum;
        for (int i = 0; i < MW; i++) mem[i] = 16'h0;
        mem[8'h00] = 16'h0040; mem[8'h01] = 16'h2041; mem[8'h02] = 16'h1050;
        mem[8'h03] = 16'h5006; mem[8'h04] = 16'h0042; mem[8'h05] = 16'h4007;
        mem[8'h06] = 16'h0043; mem[8'h07] = 16'h1051; mem[8'h08] = 16'h0050;
        mem[8'h09] = 16'h3041; mem[8'h0A] = 16'h1052; mem[8'h0B] = 16'h600E;
        mem[8'h0C] = 16'h0044; mem[8'h0D] = 16'h1053; mem[8'h0E] = stop_word;
        mem[8'h40] = x; mem[8'h41] = y;
        mem[8'h42] = 16'hAAAA; mem[8'h43] = 16'h5555; mem[8'h44] = 16'h1234;
        for (int i = 0; i < MW; i++) refm[i] = mem[i];

        // R1: hold reset, bus must stay idle
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", "req in reset", mem_req, 0);
        rst_n = 1'b1;
        #1;
        chk("R1", "pc after reset", pc_q, 0);
        chk("R1", "acc after reset", acc_q, 0);
        chk("R1", "phase after reset", fetch_phase, 1);
        chk("R1", "first address", mem_addr, 0);

        rpc = 12'h0; racc = 16'h0; rir = 16'h0; rfetch = 1'b1; parked = 0;
        for (int cyc = 0; cyc < 80 && parked < 4; cyc++) begin
            op = rir[15:12]; s = rir[11:0];
            tag = op_tag(rfetch, op);
            e_req = 1'b1; e_rnw = 1'b1; e_addr = s; e_wdata = 16'h0; take = 1'b0;
            if (rfetch) e_addr = rpc;
            else case (op)
                4'd0, 4'd2, 4'd3: ;
                4'd1: begin e_rnw = 1'b0; e_wdata = racc; end
                4'd4, 4'd5, 4'd6: begin
                    take = (op == 4'd4) || (op == 4'd5 && !racc[15]) ||
                           (op == 4'd6 && racc != 16'h0);
                    e_addr = take ? s : rpc;
                end
                default: e_req = 1'b0;
            endcase
            chk(tag, "mem_req", mem_req, e_req);
            if (e_req) begin
                chk(tag, "mem_rnw", mem_rnw, e_rnw);
                chk(tag, "mem_addr", mem_addr, e_addr);
            end
            chk("R4", "mem_wdata", mem_wdata, e_wdata);
            chk(tag, "acc", acc_q, racc);
            chk(tag, "pc", pc_q, rpc);
            chk(tag, "phase", fetch_phase, rfetch);
            if (mem_req && !mem_rnw) mem[mem_addr[7:0]] = mem_wdata;
            // advance the reference model by one cycle
            if (rfetch) begin
                rir = refm[rpc[7:0]]; rpc = rpc + 1'b1; rfetch = 1'b0;
            end else case (op)
                4'd0: begin racc = refm[s[7:0]]; rfetch = 1'b1; end
                4'd1: begin refm[s[7:0]] = racc; rfetch = 1'b1; end
                4'd2: begin racc = racc + refm[s[7:0]]; rfetch = 1'b1; end
                4'd3: begin racc = racc - refm[s[7:0]]; rfetch = 1'b1; end
                4'd4, 4'd5, 4'd6: begin
                    rir = refm[e_addr[7:0]]; rpc = e_addr + 1'b1;
                end
                default: parked++;
            endcase
            @(negedge clk);
        end
        if (parked < 4) chk("R8", "program did not stop", 0, 1);

        sum = x + y;
        chk("R3", "stored sum", mem[8'h50], sum);
        chk("R6", "sign branch result", mem[8'h51], sum[15] ? 16'hAAAA : 16'h5555);
        chk("R3", "stored difference", mem[8'h52], x);
        chk("R7", "zero branch result", mem[8'h53], (x == 16'h0) ? 16'h1234 : 16'h0);
        chk("R8", "final pc", pc_q, 12'h00F);
        chk("R8", "final acc", acc_q, (x == 16'h0) ? 16'h1234 : x);
        for (int i = 8'h40; i < 8'h60; i++) chk("R4", "data word", mem[i], refm[i]);
    endtask

    initial begin
        logic [15:0] vals [0:5];
        int run;
        vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h7FFF;
        vals[3] = 16'h8000; vals[4] = 16'hFFFF; vals[5] = 16'h0005;
        run = 0;
        @(negedge clk);
        for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++) begin
                run_prog(vals[i], vals[j], (run % 2 == 0) ? 16'h7000 : 16'hF000);
                run++;
            end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL R8 watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule